// File: doc/BRIEF.md
# Dual-Style Parallel Host Bus Port

This block is the microcontroller-facing slave port of a character display controller. A host moves instruction and data bytes over an 8-bit parallel bus. A configuration input selects one of two bus styles. In the first style, a read/write select line is qualified by an enable strobe. In the second style, separate active-low read and write strobes are used. A register-select line marks each byte as an instruction (low) or data (high).

All bus lines pass through a synchronizer into the system clock domain, and strobe edges are found there. Each completed byte leaves the port as a one-clock strobe together with its payload. The strobe goes on one of two lines, chosen by register-select.

The port decodes the bus-width bit of the function-set instruction by itself, because the width decides how it assembles bytes. In narrow mode, each byte arrives as two transfers on the upper four data lines, high nibble first. Reads return one of two values:
- a status byte, built from a busy bit that is always zero and the controller's 7-bit address counter;
- a RAM byte, supplied by the controller, which the port acknowledges with an advance pulse.

An optional active-low external reset input is synchronized, resets the port, and is passed on to the controller.

Top module: `hbus_port`

## Requirements
- R1: While `rst_n` is low and on the first cycles after it, `bus_d_oe`, `cmd_stb`, `dat_stb` and `rd_adv` are low, the bus width is 8-bit and the nibble phase is at the high nibble.
- R2: Each completed write byte raises exactly one of `cmd_stb` (register-select low) or `dat_stb` (register-select high) for one clock, with the byte on `xfer_byte`.
- R3: In enable style (`cfg_split_strobes`=0), a write is taken on the falling edge of the enable line while the read/write select is low. A falling edge of the enable line while the select is high is not a write.
- R4: In split style (`cfg_split_strobes`=1), a write is taken on the rising edge of the active-low write strobe. Read strobe activity never produces a write strobe.
- R5: In 4-bit mode, only data lines 7..4 are used. Two transfers form one byte, high nibble first, and lines 3..0 are ignored.
- R6: A write with register-select low and byte bits 7..5 = 001 is a function-set. Its bit 4 selects 8-bit (1) or 4-bit (0) width, and it is still forwarded on `cmd_stb`. A width change returns the nibble phase to the high nibble.
- R7: A read with register-select low drives {1'b0, `ac_in`}, which is a busy bit of zero in bit 7 followed by the address counter.
- R8: A read with register-select high drives `rd_byte`. When the last transfer of that byte completes, it raises `rd_adv` for one clock. Instruction reads never raise `rd_adv`.
- R9: `bus_d_oe` is high from the read-strobe assertion (enable rising with select high, or read strobe falling) until the strobe releases. `bus_d_o` is steady while it is high.
- R10: `cmd_stb`, `dat_stb` and `rd_adv` appear 3 clocks after the completing strobe edge reaches the pins.
- R11: With `EXT_RST_EN`=1, a low `ext_rst_n` drives `core_rst_n` low within 3 clocks. It also returns the port to 8-bit width with the nibble phase at the high nibble.
- R12: In 4-bit mode, a read drives the high nibble of the selected byte on lines 7..4 first, then the low nibble, with lines 3..0 at zero. The two transfers share the nibble phase with writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_rst_n | input | 1 | Asynchronous active-low external reset from the host |
| cfg_split_strobes | input | 1 | 0: enable style, 1: separate read/write strobe style |
| bus_rs | input | 1 | Register select: 0 instruction, 1 data |
| bus_rw_wrn | input | 1 | Read/write select (enable style) or active-low write strobe |
| bus_e_rdn | input | 1 | Enable strobe (enable style) or active-low read strobe |
| bus_d_i | input | 8 | Data lines from the host |
| bus_d_o | output | 8 | Read data toward the host |
| bus_d_oe | output | 1 | Output enable for the data lines |
| ac_in | input | 7 | Address counter from the controller |
| rd_byte | input | 8 | RAM byte from the controller at the current address |
| cmd_stb | output | 1 | One-clock strobe for an instruction byte |
| dat_stb | output | 1 | One-clock strobe for a data byte |
| xfer_byte | output | 8 | Byte carried with `cmd_stb` / `dat_stb` |
| rd_adv | output | 1 | One-clock pulse when a data read completes |
| core_rst_n | output | 1 | Combined active-low reset for the controller |

## Verification
Every port-side result sits behind the same three registers: two synchronizer stages, then the output register. As a result, a write strobe or `rd_adv` is due exactly 3 clocks after the bench moves the completing strobe line. The drive window opens and closes 3 clocks after the read strobe asserts and releases.

The driver records the cycle of each completing edge and queues the expected byte, or the read advance, with a due cycle of that edge plus 3. The monitor pops the queue when the pulse appears and compares both the payload and the cycle. Read data and the output enable are sampled well inside the drive window, and again after it has closed.

// File: rtl/hbus_pkg.sv
// Shared constants and types for the host bus port.
// Assumes an 8-bit bus with a 4-bit narrow mode and a 7-bit address counter.
package hbus_pkg;
    localparam int BYTE_W   = 8;
    localparam int NIB_W    = BYTE_W / 2;
    localparam int AC_W     = BYTE_W - 1;
    // function-set opcode tag in bits 7..5 and its width bit
    localparam logic [2:0] FSET_TAG   = 3'b001;
    localparam int         FSET_WBIT  = 4;

    typedef enum logic {
        STYLE_ENABLE = 1'b0,
        STYLE_SPLIT  = 1'b1
    } bus_style_e;

    // one synchronized sample of the bus
    typedef struct packed {
        logic              rs;
        logic              ctl_a;   // read/write select or write strobe
        logic              ctl_b;   // enable or read strobe
        logic [BYTE_W-1:0] d;
    } bus_smp_t;
endpackage

// File: rtl/hbus_sync.sv
// Multi-stage synchronizer for a vector of asynchronous bus lines.
// Gives the synchronized sample and the one before it for edge finding.
// On reset every stage loads the live input, so no false edge follows reset.
module hbus_sync #(
    parameter int WIDTH  = 11,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);
    logic [STAGES:0][WIDTH-1:0] stage_q;

    // shift the bus sample through the stage chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k <= STAGES; k++) stage_q[k] <= async_i;
        end else begin
            stage_q[0] <= async_i;
            for (int k = 1; k <= STAGES; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
    assign prev_o = stage_q[STAGES];
endmodule

// File: rtl/hbus_strobe.sv
// Decodes bus events from two successive synchronized samples of the controls.
// Assumes the host keeps the select line steady around each strobe edge.
module hbus_strobe
    import hbus_pkg::*;
(
    input  bus_style_e style,
    input  logic       a_now,
    input  logic       a_prev,
    input  logic       b_now,
    input  logic       b_prev,
    output logic       wr_ev,
    output logic       rd_start,
    output logic       rd_end,
    output logic       drive_end
);
    // map the two bus styles onto common write/read events
    always_comb begin
        if (style == STYLE_ENABLE) begin
            wr_ev     = b_prev & ~b_now & ~a_now;
            rd_start  = ~b_prev & b_now & a_now;
            rd_end    = b_prev & ~b_now & a_now;
            drive_end = b_prev & ~b_now;
        end else begin
            wr_ev     = ~a_prev & a_now;
            rd_start  = b_prev & ~b_now;
            rd_end    = ~b_prev & b_now;
            drive_end = ~b_prev & b_now;
        end
    end
endmodule

// File: rtl/hbus_assemble.sv
// Builds bytes from 8-bit or nibble transfers and issues one-clock strobes.
// Tracks the bus width (function-set bit) and the shared nibble phase.
module hbus_assemble
    import hbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ev,
    input  logic              rd_end,
    input  logic              rs_i,
    input  logic [BYTE_W-1:0] d_i,
    output logic              cmd_stb,
    output logic              dat_stb,
    output logic [BYTE_W-1:0] byte_o,
    output logic              rd_adv,
    output logic              wide_o,
    output logic              phase_o
);
    logic              wide_q;
    logic              phase_q;
    logic [NIB_W-1:0]  hi_q;
    logic [BYTE_W-1:0] full_byte;
    logic              done;
    logic              fset;

    // form the candidate byte and detect completion and function-set
    always_comb begin
        full_byte = wide_q ? d_i : {hi_q, d_i[BYTE_W-1 -: NIB_W]};
        done      = wr_ev & (wide_q | phase_q);
        fset      = done & ~rs_i & (full_byte[BYTE_W-1 -: 3] == FSET_TAG);
    end

    // update width, phase and strobes per bus event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide_q  <= 1'b1;
            phase_q <= 1'b0;
            hi_q    <= '0;
            cmd_stb <= 1'b0;
            dat_stb <= 1'b0;
            rd_adv  <= 1'b0;
            byte_o  <= '0;
        end else begin
            cmd_stb <= done & ~rs_i;
            dat_stb <= done & rs_i;
            rd_adv  <= 1'b0;
            if (done) byte_o <= full_byte;
            if (wr_ev) begin
                if (!wide_q) begin
                    phase_q <= ~phase_q;
                    if (!phase_q) hi_q <= d_i[BYTE_W-1 -: NIB_W];
                end
                if (fset && (full_byte[FSET_WBIT] != wide_q)) begin
                    wide_q  <= full_byte[FSET_WBIT];
                    phase_q <= 1'b0;
                end
            end else if (rd_end) begin
                if (wide_q) begin
                    rd_adv <= rs_i;
                end else begin
                    phase_q <= ~phase_q;
                    rd_adv  <= rs_i & phase_q;
                end
            end
        end
    end

    assign wide_o  = wide_q;
    assign phase_o = phase_q;
endmodule

// File: rtl/hbus_rddrv.sv
// Registers the read value and the data-line enable for one read transfer.
// Narrow mode places the selected nibble on the upper lines, lower lines zero.
module hbus_rddrv
    import hbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_start,
    input  logic              drive_end,
    input  logic              rs_i,
    input  logic              wide_i,
    input  logic              phase_i,
    input  logic [AC_W-1:0]   ac_in,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [BYTE_W-1:0] d_o,
    output logic              d_oe
);
    logic [BYTE_W-1:0] sel;
    logic [BYTE_W-1:0] shaped;

    // choose status or RAM byte and shape it for the bus width
    always_comb begin
        sel = rs_i ? rd_byte : {1'b0, ac_in};
        if (wide_i)       shaped = sel;
        else if (phase_i) shaped = {sel[NIB_W-1:0], {NIB_W{1'b0}}};
        else              shaped = {sel[BYTE_W-1 -: NIB_W], {NIB_W{1'b0}}};
    end

    // hold the drive window between strobe assertion and release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_o  <= '0;
            d_oe <= 1'b0;
        end else if (rd_start) begin
            d_o  <= shaped;
            d_oe <= 1'b1;
        end else if (drive_end) begin
            d_oe <= 1'b0;
        end
    end
endmodule

// File: rtl/hbus_port.sv
// Host parallel bus slave: synchronizes the bus, decodes either strobe style,
// assembles bytes and drives read data. Optional external reset input.
module hbus_port #(
    parameter int  SYNC_STAGES = 2,
    parameter bit  EXT_RST_EN  = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_rst_n,
    input  logic       cfg_split_strobes,
    input  logic       bus_rs,
    input  logic       bus_rw_wrn,
    input  logic       bus_e_rdn,
    input  logic [7:0] bus_d_i,
    output logic [7:0] bus_d_o,
    output logic       bus_d_oe,
    input  logic [6:0] ac_in,
    input  logic [7:0] rd_byte,
    output logic       cmd_stb,
    output logic       dat_stb,
    output logic [7:0] xfer_byte,
    output logic       rd_adv,
    output logic       core_rst_n
);
    import hbus_pkg::*;
    localparam int SMP_W = $bits(bus_smp_t);

    bus_smp_t   smp_raw, smp_now, smp_prev;
    bus_style_e style;
    logic       wr_ev, rd_start, rd_end, drive_end;
    logic       wide, phase;

    // gather the bus lines into one sample word
    always_comb begin
        smp_raw.rs    = bus_rs;
        smp_raw.ctl_a = bus_rw_wrn;
        smp_raw.ctl_b = bus_e_rdn;
        smp_raw.d     = bus_d_i;
        style         = bus_style_e'(cfg_split_strobes);
    end

    generate
        if (EXT_RST_EN) begin : g_ext_rst
            logic [1:0] ext_q;
            // bring the external reset into the clock domain
            always_ff @(posedge clk) begin
                if (!rst_n) ext_q <= 2'b11;
                else        ext_q <= {ext_q[0], ext_rst_n};
            end
            assign core_rst_n = rst_n & ext_q[1];
        end else begin : g_no_ext_rst
            logic unused_ext;
            assign unused_ext = ext_rst_n;
            assign core_rst_n = rst_n;
        end
    endgenerate

    hbus_sync #(.WIDTH(SMP_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (smp_raw),
        .sync_o  (smp_now),
        .prev_o  (smp_prev)
    );

    hbus_strobe u_strobe (
        .style     (style),
        .a_now     (smp_now.ctl_a),
        .a_prev    (smp_prev.ctl_a),
        .b_now     (smp_now.ctl_b),
        .b_prev    (smp_prev.ctl_b),
        .wr_ev     (wr_ev),
        .rd_start  (rd_start),
        .rd_end    (rd_end),
        .drive_end (drive_end)
    );

    hbus_assemble u_asm (
        .clk     (clk),
        .rst_n   (core_rst_n),
        .wr_ev   (wr_ev),
        .rd_end  (rd_end),
        .rs_i    (smp_now.rs),
        .d_i     (smp_now.d),
        .cmd_stb (cmd_stb),
        .dat_stb (dat_stb),
        .byte_o  (xfer_byte),
        .rd_adv  (rd_adv),
        .wide_o  (wide),
        .phase_o (phase)
    );

    hbus_rddrv u_rd (
        .clk       (clk),
        .rst_n     (core_rst_n),
        .rd_start  (rd_start),
        .drive_end (drive_end),
        .rs_i      (smp_now.rs),
        .wide_i    (wide),
        .phase_i   (phase),
        .ac_in     (ac_in),
        .rd_byte   (rd_byte),
        .d_o       (bus_d_o),
        .d_oe      (bus_d_oe)
    );
endmodule

// File: rtl/hbus_port_chk.sv
// Protocol checker for hbus_port, attached through bind.
// Relates the port's strobes and drive outputs over time.
module hbus_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_stb,
    input logic       dat_stb,
    input logic       rd_adv,
    input logic       bus_d_oe,
    input logic [7:0] bus_d_o
);
    // R1: reset leaves the outputs quiet
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!bus_d_oe && !cmd_stb && !dat_stb && !rd_adv));

    // R2: at most one kind of strobe per cycle
    a_r2_onehot_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_stb, dat_stb, rd_adv}));

    // R2: a write strobe lasts a single clock
    a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb || dat_stb) |=> !(cmd_stb || dat_stb));

    // R8: read advance lasts a single clock
    a_r8_single_adv: assert property (@(posedge clk) disable iff (!rst_n)
        rd_adv |=> !rd_adv);

    // R9: driven data holds for the whole window
    a_r9_steady_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_d_oe && $past(bus_d_oe)) |-> $stable(bus_d_o));
endmodule

bind hbus_port hbus_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_stb  (cmd_stb),
    .dat_stb  (dat_stb),
    .rd_adv   (rd_adv),
    .bus_d_oe (bus_d_oe),
    .bus_d_o  (bus_d_o)
);

// File: tb/test_hbus_port.sv
// Scoreboard bench: driver queues expected bytes with due cycles, monitor compares.
module test_hbus_port;
    logic       clk = 1'b0;
    logic       rst_n, ext_rst_n, cfg_split_strobes;
    logic       bus_rs, bus_rw_wrn, bus_e_rdn;
    logic [7:0] bus_d_i, bus_d_o, xfer_byte, rd_byte;
    logic [6:0] ac_in;
    logic       bus_d_oe, cmd_stb, dat_stb, rd_adv, core_rst_n;

    always #4 clk = ~clk;

    hbus_port i_hbus_port (
        .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n),
        .cfg_split_strobes(cfg_split_strobes), .bus_rs(bus_rs),
        .bus_rw_wrn(bus_rw_wrn), .bus_e_rdn(bus_e_rdn), .bus_d_i(bus_d_i),
        .bus_d_o(bus_d_o), .bus_d_oe(bus_d_oe), .ac_in(ac_in), .rd_byte(rd_byte),
        .cmd_stb(cmd_stb), .dat_stb(dat_stb), .xfer_byte(xfer_byte),
        .rd_adv(rd_adv), .core_rst_n(core_rst_n)
    );

    int cyc = 0;
    int total = 0;
    int bad = 0;
    int unexp = 0;
    logic [8:0] exp_q[$];
    int         due_q[$];
    int         adv_q[$];
    bit         model_wide = 1'b1;
    bit         style = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s got=%0h exp=%0h", req, what, got, exp);
        end
    endtask

    // monitor: pop and compare whenever the port raises a strobe
    always @(negedge clk) begin : mon
        logic [8:0] e;
        int d;
        if (rst_n) begin
            if (cmd_stb || dat_stb) begin
                if (exp_q.size() == 0) unexp++;
                else begin
                    e = exp_q.pop_front();
                    d = due_q.pop_front();
                    chk({dat_stb, xfer_byte} == e, "R2", "rs+byte", {dat_stb, xfer_byte}, e);
                    chk(cyc == d, "R10", "write latency", cyc, d);
                end
            end
            if (rd_adv) begin
                if (adv_q.size() == 0) unexp++;
                else begin
                    d = adv_q.pop_front();
                    chk(cyc == d, "R8", "read advance cycle", cyc, d);
                end
            end
        end
    end

    task automatic idle_lines();
        if (style) begin bus_rw_wrn = 1'b1; bus_e_rdn = 1'b1; end
        else       begin bus_rw_wrn = 1'b0; bus_e_rdn = 1'b0; end
    endtask

    // one write transfer; when last, queue the byte due 3 clocks after the edge
    task automatic xfer_wr(input bit rs, input logic [7:0] d, input bit last,
                           input logic [7:0] full);
        @(negedge clk);
        bus_rs = rs; bus_d_i = d;
        if (!style) bus_rw_wrn = 1'b0;
        repeat (2) @(negedge clk);
        if (style) bus_rw_wrn = 1'b0; else bus_e_rdn = 1'b1;
        repeat (4) @(negedge clk);
        if (style) bus_rw_wrn = 1'b1; else bus_e_rdn = 1'b0;
        if (last) begin exp_q.push_back({rs, full}); due_q.push_back(cyc + 3); end
        repeat (4) @(negedge clk);
    endtask

    task automatic put_byte(input bit rs, input logic [7:0] b);
        if (model_wide) xfer_wr(rs, b, 1'b1, b);
        else begin
            // R5: lines 3..0 carry junk that must be ignored
            xfer_wr(rs, {b[7:4], 4'hA}, 1'b0, b);
            xfer_wr(rs, {b[3:0], 4'h5}, 1'b1, b);
        end
        // R6: function-set width bit
        if (!rs && b[7:5] == 3'b001) model_wide = b[4];
    endtask

    // one read transfer, checking the drive window and driven value
    task automatic xfer_rd(input bit rs, input logic [7:0] exp, input bit adv,
                           input string req);
        @(negedge clk);
        bus_rs = rs;
        if (!style) bus_rw_wrn = 1'b1;
        repeat (2) @(negedge clk);
        if (style) bus_e_rdn = 1'b0; else bus_e_rdn = 1'b1;
        repeat (6) @(negedge clk);
        chk(bus_d_oe == 1'b1, "R9", "oe in window", bus_d_oe, 1);
        chk(bus_d_o == exp, req, "read value", bus_d_o, exp);
        if (style) bus_e_rdn = 1'b1; else bus_e_rdn = 1'b0;
        if (adv) adv_q.push_back(cyc + 3);
        repeat (4) @(negedge clk);
        chk(bus_d_oe == 1'b0, "R9", "oe after window", bus_d_oe, 0);
        if (!style) bus_rw_wrn = 1'b0;
    endtask

    task automatic get_byte(input bit rs, input logic [7:0] v);
        if (model_wide) xfer_rd(rs, v, rs, rs ? "R8" : "R7");
        else begin
            xfer_rd(rs, {v[7:4], 4'h0}, 1'b0, "R12");
            xfer_rd(rs, {v[3:0], 4'h0}, rs, "R12");
        end
    endtask

    task automatic do_reset(input bit st);
        @(negedge clk);
        rst_n = 1'b0;
        style = st; cfg_split_strobes = st;
        idle_lines();
        repeat (4) @(negedge clk);
        chk(!bus_d_oe && !cmd_stb && !dat_stb && !rd_adv, "R1", "outputs in reset",
            {bus_d_oe, cmd_stb, dat_stb, rd_adv}, 0);
        rst_n = 1'b1;
        model_wide = 1'b1;
        repeat (3) @(negedge clk);
        chk(!bus_d_oe && !cmd_stb && !dat_stb, "R1", "outputs after reset",
            {bus_d_oe, cmd_stb, dat_stb}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ext_rst_n = 1'b1; cfg_split_strobes = 1'b0;
        bus_rs = 1'b0; bus_d_i = 8'h00; bus_rw_wrn = 1'b0; bus_e_rdn = 1'b0;
        ac_in = 7'h5A; rd_byte = 8'hC3;

        // enable style, 8-bit (R3)
        do_reset(1'b0);
        put_byte(1'b0, 8'h38);          // R6 function-set keeping 8-bit
        put_byte(1'b1, 8'h41);
        put_byte(1'b1, 8'h7E);
        get_byte(1'b0, 8'h5A);          // R7 status: busy 0 + counter
        get_byte(1'b1, 8'hC3);          // R8 data read
        put_byte(1'b0, 8'h28);          // R6 switch to 4-bit
        put_byte(1'b1, 8'hA5);          // R5 two nibbles
        put_byte(1'b0, 8'h01);
        get_byte(1'b0, 8'h5A);          // R12 narrow status read
        get_byte(1'b1, 8'hC3);          // R12 narrow data read
        put_byte(1'b0, 8'h38);          // R6 back to 8-bit
        put_byte(1'b1, 8'h66);

        // split style (R4)
        do_reset(1'b1);
        put_byte(1'b0, 8'h30);
        put_byte(1'b1, 8'h99);
        get_byte(1'b0, 8'h5A);
        get_byte(1'b1, 8'hC3);
        put_byte(1'b0, 8'h20);
        put_byte(1'b1, 8'h3C);
        get_byte(1'b1, 8'hC3);

        // R11: external reset in the middle of a nibble pair
        xfer_wr(1'b1, 8'h70, 1'b0, 8'h00);
        @(negedge clk);
        ext_rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(core_rst_n == 1'b0, "R11", "core reset asserted", core_rst_n, 0);
        ext_rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(core_rst_n == 1'b1, "R11", "core reset released", core_rst_n, 1);
        model_wide = 1'b1;
        put_byte(1'b1, 8'h55);          // R11 single transfer after reset

        repeat (10) @(negedge clk);
        chk(unexp == 0, "R3", "no stray write or advance strobe", unexp, 0);
        chk(unexp == 0, "R4", "read strobes produced no write", unexp, 0);
        chk(exp_q.size() == 0, "R10", "all writes delivered", exp_q.size(), 0);
        chk(adv_q.size() == 0, "R8", "all advances delivered", adv_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule